// File: doc/BRIEF.md
# Transmit Low-Power-Idle Controller

This block decides when the transmit side of an Ethernet MAC may drop into the energy-saving idle state and when it has to come back out. It watches whether the MAC has nothing to send and whether a frame is waiting. It qualifies the link with a timer that counts millisecond ticks. While the idle state lasts it drives an idle-request line towards the PHY interface and holds the MAC. When traffic returns, it releases the idle request and keeps the MAC held for a programmable number of microsecond ticks, so the far end has time to wake.

Software sees two 32-bit registers on a simple select/write bus with combinational read data. The status/control word carries four control bits, two live state bits and four sticky event flags. The flags record transmit entry and exit, and receive entry and exit as reported by the PHY-side indication. Reading that word clears the flags. The summary interrupt is the OR of the flags, and it also appears at bit 10 of a 16-bit MAC interrupt status vector.

Top module: `lpi_ctrl`

## Requirements
- R1: After reset, the status/control word (offset 0x30) reads 0 and the timer word (offset 0x34) reads 0x03E80000, which is a link-stable time of 1000 and a wake time of 0. `tx_lpi_o`, `tx_hold_o`, `lpi_irq_o` and `mac_int_sts_o` are all 0.
- R2: Timer word layout: bits [15:0] hold the wake time in microsecond ticks and bits [26:16] hold the link-stable time in millisecond ticks. Bits [31:27] read as zero.
- R3: Status/control word layout. The read/write bits are bit 19 (automatic entry enable), bit 18 (use the link flag), bit 17 (link flag) and bit 16 (master enable). Bit 9 shows the receive path in idle and bit 8 the transmit path in idle. Bits 3..0 are the events: receive exit, receive entry, transmit exit, transmit entry. All other bits read 0.
- R4: With bits 16 and 19 set, `mac_idle_i` high, `frame_pend_i` low and the link stable, `tx_lpi_o` rises one cycle later and event bit 0 is set.
- R5: The link counts as good when bit 18 is 0, or when bit 18 is 1 and bit 17 is 1. It becomes stable once it has stayed good for at least the link-stable number of `tick_ms_i` pulses. Any cycle with the link not good restarts the count.
- R6: A pending frame during idle drops `tx_lpi_o` one cycle later and sets event bit 1. `tx_hold_o` then stays high until the wake-time count of `tick_us_i` pulses has been reached, plus one cycle.
- R7: Clearing bit 16 while in idle forces an exit: `tx_lpi_o` drops, event bit 1 is set and the wake hold follows.
- R8: A rising edge on `rx_lpi_i` sets event bit 2 and a falling edge sets event bit 3. Bit 9 follows `rx_lpi_i` one cycle late.
- R9: A read of the status/control word returns the flags and clears all four of them. An event that arrives in the same cycle as the read is kept.
- R10: `lpi_irq_o` and bit 10 of `mac_int_sts_o` are high exactly while any event flag is set. All other bits of `mac_int_sts_o` are 0.
- R11: `tx_hold_o` is high whenever `tx_lpi_o` is high.
- R12: A read of an unmapped offset returns 0, and a write to one changes neither register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_sel | input | 1 | Register access strobe |
| reg_wr | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 8 | Byte offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational |
| mac_idle_i | input | 1 | MAC transmitter has nothing in flight |
| frame_pend_i | input | 1 | A frame is waiting to be sent |
| rx_lpi_i | input | 1 | PHY-side receive idle indication |
| tick_us_i | input | 1 | One-cycle microsecond strobe |
| tick_ms_i | input | 1 | One-cycle millisecond strobe |
| tx_lpi_o | output | 1 | Transmit idle request to the PHY interface |
| tx_hold_o | output | 1 | Holds the MAC off transmitting |
| lpi_irq_o | output | 1 | Summary event interrupt |
| mac_int_sts_o | output | 16 | MAC interrupt status vector, bit 10 = idle events |

## Verification
Two functions can fall in the same cycle: the clear-on-read of the event flags, and the setting of a new flag by a receive-indication edge. The bench makes `rx_lpi_i` fall in the very cycle a status read is on the bus. The read data must show the flags from before that edge. Afterwards the interrupt must still be high and a second read must return only the receive-exit flag. A clear that won over the set would lose the event and fail that second read.

// File: rtl/lpi_pkg.sv
package lpi_pkg;
  localparam int LS_W  = 11;
  localparam int TW_W  = 16;
  localparam int REG_W = 32;

  // status/control field positions
  localparam int POS_CTL  = 16;   // four control bits [19:16]
  localparam int POS_RXST = 9;
  localparam int POS_TXST = 8;
  localparam int POS_LS   = 16;   // timer word link-stable field
  localparam int IRQ_BIT  = 10;

  // control vector index (ctl[3:0] = {auto, use_link, link, enable})
  localparam int C_EN = 0, C_LINK = 1, C_USE = 2, C_AUTO = 3;
  // event index
  localparam int E_TX_IN = 0, E_TX_OUT = 1, E_RX_IN = 2, E_RX_OUT = 3;

  typedef enum logic [1:0] {TX_RUN, TX_LPI, TX_WAKE} tx_state_e;

  function automatic logic [REG_W-1:0] pack_csr(input logic [3:0] ctl,
      input logic rxst, input logic txst, input logic [3:0] ev);
    logic [REG_W-1:0] v;
    v = '0;
    v[POS_CTL +: 4] = ctl;
    v[POS_RXST]     = rxst;
    v[POS_TXST]     = txst;
    v[3:0]          = ev;
    return v;
  endfunction

  function automatic logic [REG_W-1:0] pack_tmr(input logic [LS_W-1:0] ls,
      input logic [TW_W-1:0] tw);
    logic [REG_W-1:0] v;
    v = '0;
    v[POS_LS +: LS_W] = ls;
    v[0 +: TW_W]      = tw;
    return v;
  endfunction

  function automatic logic link_ready(input logic [LS_W-1:0] cnt,
      input logic [LS_W-1:0] lim);
    return cnt >= lim;
  endfunction

  function automatic logic wake_done(input logic [TW_W-1:0] cnt,
      input logic [TW_W-1:0] lim);
    return cnt >= lim;
  endfunction
endpackage

// File: rtl/lpi_link_timer.sv
module lpi_link_timer
  import lpi_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            link_ok,
  input  logic            tick_ms,
  input  logic [LS_W-1:0] lim,
  output logic            stable
);
  logic [LS_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)                              cnt <= '0;
    else if (!link_ok)                       cnt <= '0;
    else if (tick_ms && !link_ready(cnt, lim)) cnt <= cnt + 1'b1;
  end

  assign stable = link_ok && link_ready(cnt, lim);

  // R5
  link_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !link_ok |=> cnt == '0);
endmodule

// File: rtl/lpi_tx_seq.sv
module lpi_tx_seq
  import lpi_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            lpi_en,
  input  logic            auto_en,
  input  logic            mac_idle,
  input  logic            frame_pend,
  input  logic            link_stable,
  input  logic            tick_us,
  input  logic [TW_W-1:0] tw,
  output logic            tx_lpi,
  output logic            tx_hold,
  output logic            ev_entry,
  output logic            ev_exit
);
  tx_state_e       state;
  logic [TW_W-1:0] wk_cnt;
  logic            go_sleep, go_wake, wake_fin;

  assign go_sleep = (state == TX_RUN) && lpi_en && auto_en && mac_idle &&
                    !frame_pend && link_stable;
  assign go_wake  = (state == TX_LPI) && (frame_pend || !lpi_en || !auto_en);
  assign wake_fin = (state == TX_WAKE) && wake_done(wk_cnt, tw);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= TX_RUN;
      wk_cnt <= '0;
    end else begin
      if (go_sleep)      state <= TX_LPI;
      else if (go_wake)  state <= TX_WAKE;
      else if (wake_fin) state <= TX_RUN;

      if (go_wake)
        wk_cnt <= '0;
      else if ((state == TX_WAKE) && tick_us && !wake_fin)
        wk_cnt <= wk_cnt + 1'b1;
    end
  end

  assign tx_lpi   = (state == TX_LPI);
  assign tx_hold  = (state != TX_RUN);
  assign ev_entry = go_sleep;
  assign ev_exit  = go_wake;

  // R11
  lpi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_lpi |-> tx_hold);
  // R4
  entry_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_lpi) |-> $past(lpi_en && auto_en && mac_idle && !frame_pend && link_stable));
  // R6
  exit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tx_lpi) |-> tx_hold);
  // R7
  force_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_lpi && !lpi_en) |=> !tx_lpi);
endmodule

// File: rtl/lpi_regs.sv
module lpi_regs
  import lpi_pkg::*;
#(
  parameter int              ADDR_W  = 8,
  parameter logic [ADDR_W-1:0] CSR_OFS = 8'h30,
  parameter logic [ADDR_W-1:0] TMR_OFS = 8'h34,
  parameter logic [LS_W-1:0] LS_RST  = 11'd1000,
  parameter logic [TW_W-1:0] TW_RST  = '0
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [REG_W-1:0]  wdata,
  output logic [REG_W-1:0]  rdata,
  input  logic [3:0]        ev_set,
  input  logic              rx_st,
  input  logic              tx_st,
  output logic [3:0]        ctl,
  output logic [LS_W-1:0]   ls_time,
  output logic [TW_W-1:0]   tw_time,
  output logic              irq
);
  logic       csr_hit, tmr_hit, rd_csr;
  logic [3:0] ev;
  logic       wdata_unused;

  assign csr_hit = sel && (addr == CSR_OFS);
  assign tmr_hit = sel && (addr == TMR_OFS);
  assign rd_csr  = csr_hit && !wr;
  assign wdata_unused = ^{wdata[REG_W-1:POS_CTL+4], wdata[POS_CTL-1:0]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl     <= '0;
      ls_time <= LS_RST;
      tw_time <= TW_RST;
      ev      <= '0;
    end else begin
      if (csr_hit && wr) ctl <= wdata[POS_CTL +: 4];
      if (tmr_hit && wr) begin
        ls_time <= wdata[POS_LS +: LS_W];
        tw_time <= wdata[0 +: TW_W];
      end
      ev <= (rd_csr ? 4'b0 : ev) | ev_set;
    end
  end

  always_comb begin
    if (csr_hit)      rdata = pack_csr(ctl, rx_st, tx_st, ev);
    else if (tmr_hit) rdata = pack_tmr(ls_time, tw_time);
    else              rdata = '0;
  end

  assign irq = |ev;

  // R9
  clr_on_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_csr && ev_set == 4'b0) |=> ev == 4'b0);
  // R10
  irq_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_set != 4'b0) |=> irq);
endmodule

// File: rtl/lpi_ctrl.sv
module lpi_ctrl
  import lpi_pkg::*;
#(
  parameter int                ADDR_W  = 8,
  parameter logic [ADDR_W-1:0] CSR_OFS = 8'h30,
  parameter logic [ADDR_W-1:0] TMR_OFS = 8'h34,
  parameter int                IRQ_W   = 16
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_sel,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              mac_idle_i,
  input  logic              frame_pend_i,
  input  logic              rx_lpi_i,
  input  logic              tick_us_i,
  input  logic              tick_ms_i,
  output logic              tx_lpi_o,
  output logic              tx_hold_o,
  output logic              lpi_irq_o,
  output logic [IRQ_W-1:0]  mac_int_sts_o
);
  logic [3:0]      ctl, ev_set;
  logic [LS_W-1:0] ls_time;
  logic [TW_W-1:0] tw_time;
  logic            link_ok, link_stable, rx_q, ev_entry, ev_exit, irq;

  always_ff @(posedge clk) begin
    if (!rst_n) rx_q <= 1'b0;
    else        rx_q <= rx_lpi_i;
  end

  assign link_ok = ctl[C_USE] ? ctl[C_LINK] : 1'b1;

  always_comb begin
    ev_set           = '0;
    ev_set[E_TX_IN]  = ev_entry;
    ev_set[E_TX_OUT] = ev_exit;
    ev_set[E_RX_IN]  = rx_lpi_i && !rx_q;
    ev_set[E_RX_OUT] = !rx_lpi_i && rx_q;
  end

  lpi_regs #(.ADDR_W(ADDR_W), .CSR_OFS(CSR_OFS), .TMR_OFS(TMR_OFS)) regs_i (
    .clk(clk), .rst_n(rst_n), .sel(reg_sel), .wr(reg_wr), .addr(reg_addr),
    .wdata(reg_wdata), .rdata(reg_rdata), .ev_set(ev_set), .rx_st(rx_q),
    .tx_st(tx_lpi_o), .ctl(ctl), .ls_time(ls_time), .tw_time(tw_time), .irq(irq)
  );

  lpi_link_timer link_i (
    .clk(clk), .rst_n(rst_n), .link_ok(link_ok), .tick_ms(tick_ms_i),
    .lim(ls_time), .stable(link_stable)
  );

  lpi_tx_seq seq_i (
    .clk(clk), .rst_n(rst_n), .lpi_en(ctl[C_EN]), .auto_en(ctl[C_AUTO]),
    .mac_idle(mac_idle_i), .frame_pend(frame_pend_i), .link_stable(link_stable),
    .tick_us(tick_us_i), .tw(tw_time), .tx_lpi(tx_lpi_o), .tx_hold(tx_hold_o),
    .ev_entry(ev_entry), .ev_exit(ev_exit)
  );

  always_comb begin
    mac_int_sts_o          = '0;
    mac_int_sts_o[IRQ_BIT] = irq;
  end
  assign lpi_irq_o = irq;

  // R8
  rx_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_q) |-> $past(ev_set[E_RX_IN]));
endmodule

// File: tb/lpi_ctrl_tb_top.sv
module lpi_ctrl_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_sel = 0, reg_wr = 0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic mac_idle = 0, frame_pend = 0, rx_lpi = 0, tick_us = 0, tick_ms = 0;
  logic tx_lpi, tx_hold, irq;
  logic [15:0] int_sts;
  int checks = 0, errors = 0;
  bit done = 0;

  localparam logic [7:0]  CSR = 8'h30, TMR = 8'h34;
  localparam logic [31:0] K_AUTO = 32'h80000, K_USE = 32'h40000,
                          K_LINK = 32'h20000, K_EN = 32'h10000;

  always #10 clk = ~clk;

  lpi_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .mac_idle_i(mac_idle), .frame_pend_i(frame_pend), .rx_lpi_i(rx_lpi),
    .tick_us_i(tick_us), .tick_ms_i(tick_ms), .tx_lpi_o(tx_lpi),
    .tx_hold_o(tx_hold), .lpi_irq_o(irq), .mac_int_sts_o(int_sts)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_sel = 1; reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_sel = 0; reg_wr = 0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_sel = 1; reg_wr = 0; reg_addr = a;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_sel = 0;
  endtask

  task automatic pulse_ms(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick_ms = 1;
      @(negedge clk); tick_ms = 0;
    end
  endtask

  task automatic pulse_us(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick_us = 1;
      @(negedge clk); tick_us = 0;
    end
  endtask

  task automatic t_reset;
    logic [31:0] d;
    chk("R1 tx_lpi", {31'b0, tx_lpi}, 0);
    chk("R1 hold", {31'b0, tx_hold}, 0);
    chk("R1 irq", {16'b0, int_sts}, 0);
    bus_read(CSR, d); chk("R1 csr", d, 32'h0);
    bus_read(TMR, d); chk("R1 timer", d, 32'h03E80000);
  endtask

  task automatic t_regs;
    logic [31:0] d;
    bus_write(TMR, 32'hFFFFFFFF);
    bus_read(TMR, d); chk("R2 timer layout", d, 32'h07FFFFFF);
    bus_write(CSR, 32'hFFFFFFFF);
    bus_read(CSR, d); chk("R3 csr layout", d, 32'h000F0000);
    bus_write(CSR, 32'h0);
    bus_write(8'h40, 32'hFFFFFFFF);
    bus_read(8'h40, d); chk("R12 unmapped read", d, 32'h0);
    bus_read(CSR, d); chk("R12 csr untouched", d, 32'h0);
    bus_read(TMR, d); chk("R12 timer untouched", d, 32'h07FFFFFF);
  endtask

  task automatic t_entry;
    logic [31:0] d;
    bus_write(TMR, (32'd3 << 16) | 32'd2);
    mac_idle = 1; frame_pend = 0;
    bus_write(CSR, K_AUTO | K_USE | K_EN);
    pulse_ms(4);
    chk("R5 link bad blocks entry", {31'b0, tx_lpi}, 0);
    bus_write(CSR, K_AUTO | K_USE | K_LINK | K_EN);
    pulse_ms(2);
    chk("R5 two ticks short", {31'b0, tx_lpi}, 0);
    pulse_ms(1);
    chk("R5 stable count just reached", {31'b0, tx_lpi}, 0);
    @(negedge clk);
    chk("R4 entry", {31'b0, tx_lpi}, 1);
    chk("R11 hold in idle", {31'b0, tx_hold}, 1);
    chk("R10 irq vector", {16'b0, int_sts}, 32'h400);
    bus_read(CSR, d); chk("R4 entry flag", d, 32'h000F0101);
    chk("R9 irq cleared", {31'b0, irq}, 0);
  endtask

  task automatic t_wake;
    logic [31:0] d;
    @(negedge clk); frame_pend = 1;
    @(negedge clk);
    chk("R6 lpi drops", {31'b0, tx_lpi}, 0);
    chk("R6 hold kept", {31'b0, tx_hold}, 1);
    chk("R10 irq on exit", {31'b0, irq}, 1);
    pulse_us(2);
    chk("R6 hold at count", {31'b0, tx_hold}, 1);
    @(negedge clk);
    chk("R6 hold released", {31'b0, tx_hold}, 0);
    bus_read(CSR, d); chk("R6 exit flag", d, 32'h000F0002);
    frame_pend = 0;
    @(negedge clk);
    chk("R4 re-entry", {31'b0, tx_lpi}, 1);
  endtask

  task automatic t_force;
    logic [31:0] d;
    bus_write(CSR, K_AUTO | K_USE | K_LINK);
    chk("R7 still idle at write edge", {31'b0, tx_lpi}, 1);
    @(negedge clk);
    chk("R7 forced exit", {31'b0, tx_lpi}, 0);
    chk("R7 hold", {31'b0, tx_hold}, 1);
    bus_read(CSR, d); chk("R7 exit flag", d, 32'h000E0003);
    bus_write(TMR, 32'd3 << 16);
    @(negedge clk);
    chk("R6 zero wait release", {31'b0, tx_hold}, 0);
  endtask

  task automatic t_restart;
    logic [31:0] d;
    frame_pend = 1;
    bus_write(CSR, K_AUTO | K_USE | K_EN);
    bus_write(CSR, K_AUTO | K_USE | K_LINK | K_EN);
    frame_pend = 0;
    @(negedge clk); @(negedge clk);
    chk("R5 count restarted", {31'b0, tx_lpi}, 0);
    pulse_ms(3);
    @(negedge clk);
    chk("R5 entry after recount", {31'b0, tx_lpi}, 1);
    frame_pend = 1;
    @(negedge clk); @(negedge clk);
    chk("R6 back to run", {30'b0, tx_lpi, tx_hold}, 0);
    bus_read(CSR, d);
  endtask

  task automatic t_rx;
    logic [31:0] d;
    @(negedge clk); rx_lpi = 1;
    @(negedge clk);
    bus_read(CSR, d); chk("R8 rx entry", d, 32'h000F0204);
    @(negedge clk);
    reg_sel = 1; reg_wr = 0; reg_addr = CSR; rx_lpi = 0;
    #1 d = reg_rdata;
    @(negedge clk); reg_sel = 0;
    chk("R9 read before event", d, 32'h000F0200);
    chk("R9 event kept", {31'b0, irq}, 1);
    bus_read(CSR, d); chk("R8 rx exit", d, 32'h000F0008);
    chk("R10 irq low", {16'b0, int_sts}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_regs();
    t_entry();
    t_wake();
    t_force();
    t_restart();
    t_rx();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule